// File: doc/BRIEF.md
# Conversion Queue Freeze and Stop Controller

This block sits beside a queued conversion sequencer and decides when that sequencer must halt. It handles two situations: a debug halt requested by the processor, and a low-power stop. A debug halt takes effect only when the debug-enable configuration bit is set. If a conversion is in flight when the halt is requested, the block lets that conversion finish first. It does not wait if the active queue's operating mode changes, or the second queue is aborted, before the conversion ends.

On entry to the frozen state with a queue running, the block records the sequencer's current command-word pointer. While frozen, software may replace that recorded pointer. When the debug request drops, the block emits a one-cycle resume pulse. With that pulse it hands the sequencer three things: the pointer to use, the queue operating modes it sampled at exit, and the trigger events still pending, so the sequencer can choose the next command word. A stop bit, or a system-wide stop request, puts the block into a low-power idle state that switches the converter off.

Top module: `conv_freeze_ctrl`

## Requirements
- R1: After reset, `frozen` is 0, `convEn`, `anaClkEn` and `trigCapEn` are 1, `timerRst` is 0, `savedPtr` is 0, `resumePulse` is 0 and `pendTrig` is all zeros.
- R2: While `dbgEn` is 0, a `dbgReq` that arrives with the block not frozen never raises `frozen`.
- R3: With `dbgEn`=1 and `convBusy`=0, a `dbgReq` sampled at a clock edge makes `frozen` read 1 right after that same edge.
- R4: With `dbgEn`=1 and `convBusy`=1, `frozen` stays 0 until `convDone` is sampled high; it reads 1 right after that edge.
- R5: While a freeze is waiting on a conversion, or at the request edge itself, a sampled `modeChange` or `q2Abort` makes `frozen` read 1 right after that edge, without waiting for `convDone`.
- R6: At the edge where the block freezes, `savedPtr` takes `curPtr` if `queueActive`=1. If `queueActive`=0, `savedPtr` keeps its old value.
- R7: While `frozen`=1, `anaClkEn`=0, `timerRst`=1 and `trigCapEn`=0.
- R8: While `frozen`=1, a cycle with `swPtrWe`=1 loads `swPtrData` into `savedPtr`. While `frozen`=0, `swPtrWe` has no effect on `savedPtr`.
- R9: `frozen` and `timerRst` read 0 in the cycle after the one in which `dbgReq` is sampled low. In that same cycle `resumePulse`=1 for exactly one cycle, `resumePtr` equals `savedPtr`, and `resumeModes` equals `qModes` sampled at the exit edge.
- R10: One cycle after `stopCfg` or `sysStopReq` is sampled high, `convEn`, `anaClkEn` and `trigCapEn` are 0. While stopped, a debug request does not raise `frozen`.
- R11: A rising edge on `trigIn[i]` sets `pendTrig[i]` only when `trigCapEn`=1. Edges seen while frozen or stopped are dropped. Bits that were already set stay set until `trigAck[i]` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgReq | input | 1 | Debug halt request from the processor |
| dbgEn | input | 1 | Configuration: honour debug halts |
| stopCfg | input | 1 | Configuration: local stop |
| sysStopReq | input | 1 | System low-power stop request |
| queueActive | input | 1 | Sequencer has a queue executing |
| convBusy | input | 1 | A conversion is in flight |
| convDone | input | 1 | Conversion completion pulse |
| modeChange | input | 1 | Active queue operating mode changed |
| q2Abort | input | 1 | Second queue aborted |
| curPtr | input | PTR_W | Current command-word pointer |
| qModes | input | 2*MODE_W | Operating modes of both queues |
| swPtrWe | input | 1 | Software write strobe for the saved pointer |
| swPtrData | input | PTR_W | Software value for the saved pointer |
| trigIn | input | NTRIG | External trigger lines |
| trigAck | input | NTRIG | Sequencer acknowledges pending triggers |
| frozen | output | 1 | Debug freeze flag |
| anaClkEn | output | 1 | Analog clock enable |
| timerRst | output | 1 | Periodic/interval timer reset |
| trigCapEn | output | 1 | Trigger capture enable |
| convEn | output | 1 | Converter power enable |
| savedPtr | output | PTR_W | Saved command-word pointer |
| resumePulse | output | 1 | One-cycle resume strobe |
| resumePtr | output | PTR_W | Pointer handed back on resume |
| resumeModes | output | 2*MODE_W | Queue modes sampled at resume |
| pendTrig | output | NTRIG | Pending trigger events |

## Verification
A state register stuck in the waiting state or skipping it shows at the `frozen` port within one cycle of the request, a done pulse, or an abort. A wrong stop register shows at `convEn` one cycle after the stop input moves. Pointer capture faults show on `savedPtr` at the freeze edge and reappear on `resumePtr` with the resume pulse. A faulty trigger gate shows as a `pendTrig` bit set after a frozen-time edge, and that bit persists until it is acknowledged.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_FROZEN = 2'd2
  } frzState_t;

  typedef struct packed {
    logic capturePtr;   // latch curPtr this edge
    logic resumeNow;    // leaving frozen this edge
    logic frozenNow;    // freeze state active
    logic stoppedNow;   // low-power stop active
  } ctrlStrobe_t;
endpackage

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
  import cfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dbgReq,
  input  logic        dbgEn,
  input  logic        stopCfg,
  input  logic        sysStopReq,
  input  logic        queueActive,
  input  logic        convBusy,
  input  logic        convDone,
  input  logic        modeChange,
  input  logic        q2Abort,
  output ctrlStrobe_t strb
);
  frzState_t state, stateNext;
  logic stopQ;
  logic reqOn, quickCut, enterFrozen;

  assign reqOn    = dbgReq && dbgEn && !stopQ;
  assign quickCut = modeChange || q2Abort;

  always_comb begin
    stateNext   = state;
    enterFrozen = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (reqOn) begin
          if (convBusy && !convDone && !quickCut) begin
            stateNext = ST_WAIT;
          end else begin
            stateNext   = ST_FROZEN;
            enterFrozen = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!(dbgReq && dbgEn)) begin
          stateNext = ST_RUN;
        end else if (convDone || quickCut) begin
          stateNext   = ST_FROZEN;
          enterFrozen = 1'b1;
        end
      end
      ST_FROZEN: begin
        if (!dbgReq) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      stopQ <= 1'b0;
    end else begin
      state <= stateNext;
      stopQ <= stopCfg || sysStopReq;
    end
  end

  always_comb begin
    strb.capturePtr = enterFrozen && queueActive;
    strb.resumeNow  = (state == ST_FROZEN) && !dbgReq;
    strb.frozenNow  = (state == ST_FROZEN);
    strb.stoppedNow = stopQ;
  end
endmodule

// File: rtl/cfc_datapath.sv
module cfc_datapath
  import cfc_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int MODE_W = 3,
  parameter int NTRIG  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [PTR_W-1:0]      curPtr,
  input  logic [2*MODE_W-1:0]   qModes,
  input  logic                  swPtrWe,
  input  logic [PTR_W-1:0]      swPtrData,
  input  logic [NTRIG-1:0]      trigIn,
  input  logic [NTRIG-1:0]      trigAck,
  output logic                  frozen,
  output logic                  anaClkEn,
  output logic                  timerRst,
  output logic                  trigCapEn,
  output logic                  convEn,
  output logic [PTR_W-1:0]      savedPtr,
  output logic                  resumePulse,
  output logic [PTR_W-1:0]      resumePtr,
  output logic [2*MODE_W-1:0]   resumeModes,
  output logic [NTRIG-1:0]      pendTrig
);
  logic [NTRIG-1:0] trigPrev;
  logic             capEn;

  assign capEn     = !strb.frozenNow && !strb.stoppedNow;
  assign frozen    = strb.frozenNow;
  assign timerRst  = strb.frozenNow;
  assign anaClkEn  = capEn;
  assign trigCapEn = capEn;
  assign convEn    = !strb.stoppedNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPtr <= '0;
    end else if (strb.capturePtr) begin
      savedPtr <= curPtr;
    end else if (strb.frozenNow && swPtrWe) begin
      savedPtr <= swPtrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resumePulse <= 1'b0;
      resumePtr   <= '0;
      resumeModes <= '0;
    end else begin
      resumePulse <= strb.resumeNow;
      if (strb.resumeNow) begin
        resumePtr   <= savedPtr;
        resumeModes <= qModes;
      end
    end
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    always_ff @(posedge clk) begin
      if (!rstN) begin
        trigPrev[i] <= 1'b0;
        pendTrig[i] <= 1'b0;
      end else begin
        trigPrev[i] <= trigIn[i];
        if (trigAck[i]) begin
          pendTrig[i] <= 1'b0;
        end else if (capEn && trigIn[i] && !trigPrev[i]) begin
          pendTrig[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_freeze_ctrl.sv
module conv_freeze_ctrl
  import cfc_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int MODE_W = 3,
  parameter int NTRIG  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dbgReq,
  input  logic                  dbgEn,
  input  logic                  stopCfg,
  input  logic                  sysStopReq,
  input  logic                  queueActive,
  input  logic                  convBusy,
  input  logic                  convDone,
  input  logic                  modeChange,
  input  logic                  q2Abort,
  input  logic [PTR_W-1:0]      curPtr,
  input  logic [2*MODE_W-1:0]   qModes,
  input  logic                  swPtrWe,
  input  logic [PTR_W-1:0]      swPtrData,
  input  logic [NTRIG-1:0]      trigIn,
  input  logic [NTRIG-1:0]      trigAck,
  output logic                  frozen,
  output logic                  anaClkEn,
  output logic                  timerRst,
  output logic                  trigCapEn,
  output logic                  convEn,
  output logic [PTR_W-1:0]      savedPtr,
  output logic                  resumePulse,
  output logic [PTR_W-1:0]      resumePtr,
  output logic [2*MODE_W-1:0]   resumeModes,
  output logic [NTRIG-1:0]      pendTrig
);
  ctrlStrobe_t strb;

  cfc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .dbgEn(dbgEn),
    .stopCfg(stopCfg), .sysStopReq(sysStopReq), .queueActive(queueActive),
    .convBusy(convBusy), .convDone(convDone), .modeChange(modeChange),
    .q2Abort(q2Abort), .strb(strb)
  );

  cfc_datapath #(.PTR_W(PTR_W), .MODE_W(MODE_W), .NTRIG(NTRIG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curPtr(curPtr), .qModes(qModes),
    .swPtrWe(swPtrWe), .swPtrData(swPtrData), .trigIn(trigIn),
    .trigAck(trigAck), .frozen(frozen), .anaClkEn(anaClkEn),
    .timerRst(timerRst), .trigCapEn(trigCapEn), .convEn(convEn),
    .savedPtr(savedPtr), .resumePulse(resumePulse), .resumePtr(resumePtr),
    .resumeModes(resumeModes), .pendTrig(pendTrig)
  );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int PTR_W = 6,
  parameter int NTRIG = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             dbgReq,
  input logic             dbgEn,
  input logic             stopCfg,
  input logic             sysStopReq,
  input logic             convBusy,
  input logic             convDone,
  input logic             modeChange,
  input logic             q2Abort,
  input logic             frozen,
  input logic             anaClkEn,
  input logic             timerRst,
  input logic             trigCapEn,
  input logic             convEn,
  input logic             resumePulse,
  input logic [NTRIG-1:0] pendTrig
);
  assert_no_freeze_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && !dbgEn) |=> !frozen);

  assert_wait_for_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && convEn && dbgReq && dbgEn && convBusy && !convDone && !modeChange && !q2Abort)
      |=> !frozen);

  assert_frozen_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> (!anaClkEn && timerRst && !trigCapEn));

  assert_resume_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !dbgReq) |=> (!frozen && !timerRst && resumePulse));

  assert_stop_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopCfg || sysStopReq) |=> (!convEn && !anaClkEn && !trigCapEn));

  assert_no_capture_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    !trigCapEn |=> ((pendTrig & ~$past(pendTrig)) == '0));
endmodule

bind conv_freeze_ctrl cfc_checker #(.PTR_W(PTR_W), .NTRIG(NTRIG)) u_chk (
  .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .dbgEn(dbgEn), .stopCfg(stopCfg),
  .sysStopReq(sysStopReq), .convBusy(convBusy), .convDone(convDone),
  .modeChange(modeChange), .q2Abort(q2Abort), .frozen(frozen),
  .anaClkEn(anaClkEn), .timerRst(timerRst), .trigCapEn(trigCapEn),
  .convEn(convEn), .resumePulse(resumePulse), .pendTrig(pendTrig)
);

// File: tb/sim_conv_freeze_ctrl.sv
`timescale 1ns/1ps
module sim_conv_freeze_ctrl;
  localparam int PTR_W  = 6;
  localparam int MODE_W = 3;
  localparam int NTRIG  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgReq = 0, dbgEn = 0, stopCfg = 0, sysStopReq = 0;
  logic queueActive = 0, convBusy = 0, convDone = 0, modeChange = 0, q2Abort = 0;
  logic [PTR_W-1:0] curPtr = '0, swPtrData = '0;
  logic [2*MODE_W-1:0] qModes = '0;
  logic swPtrWe = 0;
  logic [NTRIG-1:0] trigIn = '0, trigAck = '0;
  logic frozen, anaClkEn, timerRst, trigCapEn, convEn, resumePulse;
  logic [PTR_W-1:0] savedPtr, resumePtr;
  logic [2*MODE_W-1:0] resumeModes;
  logic [NTRIG-1:0] pendTrig;

  always #4 clk = ~clk;

  conv_freeze_ctrl #(.PTR_W(PTR_W), .MODE_W(MODE_W), .NTRIG(NTRIG)) u0 (.*);

  typedef struct {
    string tag;
    bit    fz;
    bit    stp;
    int    saved;
    bit    pulse;
    int    rptr;
    int    rmodes;
    int    pend;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic step(string tag, bit fz, bit stp, int saved, bit pulse,
                      int rptr, int rmodes, int pend);
    exp_t e;
    e.tag = tag; e.fz = fz; e.stp = stp; e.saved = saved; e.pulse = pulse;
    e.rptr = rptr; e.rmodes = rmodes; e.pend = pend;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      bit bad;
      e = expQ.pop_front();
      checks++;
      bad = (frozen !== e.fz) || (timerRst !== e.fz) ||
            (anaClkEn !== !(e.fz || e.stp)) || (trigCapEn !== !(e.fz || e.stp)) ||
            (convEn !== !e.stp) || (int'(savedPtr) != e.saved) ||
            (resumePulse !== e.pulse) || (int'(pendTrig) != e.pend);
      if (e.pulse && !bad)
        bad = (int'(resumePtr) != e.rptr) || (int'(resumeModes) != e.rmodes);
      if (bad) begin
        errors++;
        $display("FAIL %s: got fz=%0b clk=%0b tmr=%0b cap=%0b conv=%0b sp=%0d rp=%0b rptr=%0d rm=%0d pend=%0d; exp fz=%0b stp=%0b sp=%0d rp=%0b rptr=%0d rm=%0d pend=%0d",
          e.tag, frozen, anaClkEn, timerRst, trigCapEn, convEn, savedPtr,
          resumePulse, resumePtr, resumeModes, pendTrig,
          e.fz, e.stp, e.saved, e.pulse, e.rptr, e.rmodes, e.pend);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step("R1 reset state", 0, 0, 0, 0, 0, 0, 0);

    // R2: debug disabled
    dbgReq = 1; dbgEn = 0;
    step("R2 disabled req", 0, 0, 0, 0, 0, 0, 0);
    step("R2 disabled req hold", 0, 0, 0, 0, 0, 0, 0);
    dbgReq = 0;
    step("R2 idle", 0, 0, 0, 0, 0, 0, 0);

    // R3/R6: immediate freeze with queue active
    dbgEn = 1; queueActive = 1; curPtr = 5; dbgReq = 1;
    step("R3 R6 immediate freeze", 1, 0, 5, 0, 0, 0, 0);
    curPtr = 6;
    step("R7 frozen hold", 1, 0, 5, 0, 0, 0, 0);
    swPtrWe = 1; swPtrData = 9;
    step("R8 sw pointer write", 1, 0, 9, 0, 0, 0, 0);
    swPtrWe = 0; qModes = 6'b101_011; dbgReq = 0;
    step("R9 resume", 0, 0, 9, 1, 9, 6'b101_011, 0);
    step("R9 pulse single", 0, 0, 9, 0, 0, 0, 0);
    swPtrWe = 1; swPtrData = 12;
    step("R8 write ignored when running", 0, 0, 9, 0, 0, 0, 0);
    swPtrWe = 0;

    // R4: wait for conversion
    convBusy = 1; curPtr = 7; dbgReq = 1;
    step("R4 pending 1", 0, 0, 9, 0, 0, 0, 0);
    step("R4 pending 2", 0, 0, 9, 0, 0, 0, 0);
    convDone = 1;
    step("R4 freeze after done", 1, 0, 7, 0, 0, 0, 0);
    convDone = 0; convBusy = 0; dbgReq = 0;
    step("R4 R9 resume", 0, 0, 7, 1, 7, 6'b101_011, 0);

    // R5: mode change while waiting
    convBusy = 1; curPtr = 11; dbgReq = 1;
    step("R5 pending", 0, 0, 7, 0, 0, 0, 0);
    modeChange = 1;
    step("R5 mode change cut", 1, 0, 11, 0, 0, 0, 0);
    modeChange = 0; dbgReq = 0; convBusy = 0;
    step("R5 resume", 0, 0, 11, 1, 11, 6'b101_011, 0);
    convBusy = 1; q2Abort = 1; curPtr = 13; dbgReq = 1;
    step("R5 abort at request", 1, 0, 13, 0, 0, 0, 0);
    q2Abort = 0; convBusy = 0; dbgReq = 0;
    step("R5 abort resume", 0, 0, 13, 1, 13, 6'b101_011, 0);

    // R6: no queue active
    queueActive = 0; curPtr = 20; dbgReq = 1;
    step("R6 no capture", 1, 0, 13, 0, 0, 0, 0);
    dbgReq = 0;
    step("R6 resume", 0, 0, 13, 1, 13, 6'b101_011, 0);

    // R11: triggers
    trigIn = 2'b01;
    step("R11 capture running", 0, 0, 13, 0, 0, 0, 1);
    trigIn = 2'b00; dbgReq = 1;
    step("R11 freeze keeps pending", 1, 0, 13, 0, 0, 0, 1);
    trigIn = 2'b10;
    step("R11 edge while frozen dropped", 1, 0, 13, 0, 0, 0, 1);
    trigIn = 2'b00; dbgReq = 0;
    step("R11 resume", 0, 0, 13, 1, 13, 6'b101_011, 1);
    step("R11 still pending", 0, 0, 13, 0, 0, 0, 1);
    trigAck = 2'b01;
    step("R11 ack clears", 0, 0, 13, 0, 0, 0, 0);
    trigAck = 2'b00;

    // R10: stop
    stopCfg = 1;
    step("R10 stop bit", 0, 1, 13, 0, 0, 0, 0);
    dbgReq = 1;
    step("R10 stop over debug", 0, 1, 13, 0, 0, 0, 0);
    trigIn = 2'b10;
    step("R10 R11 trigger in stop", 0, 1, 13, 0, 0, 0, 0);
    stopCfg = 0; sysStopReq = 1; dbgReq = 0;
    step("R10 system stop", 0, 1, 13, 0, 0, 0, 0);
    sysStopReq = 0; trigIn = 2'b00;
    step("R10 wake", 0, 0, 13, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule